// File: doc/BRIEF.md
# Quadrant-folded CORDIC sine/cosine generator

This block produces the cosine and sine of an angle, for use as twiddle factors in an FFT datapath. The angle is given in unsigned fixed-point degrees. The block reflects the angle into the first quadrant and remembers, as two separate flags, whether cosine and sine must be negated. It then runs rotation-mode CORDIC micro-rotations, one per clock, built only from adders and arithmetic shifts. The elementary arctangent angles are hard-wired constants in logic. The start vector already carries the inverse CORDIC gain, so no gain multiplier follows the iterations.

A working angle that lies within 5° of either axis is snapped, and the block then returns the exact axis values instead of the approximate CORDIC result. The caller pulses `start` with `angle_in` valid. The result appears on `cos_out`/`sin_out` together with a one-cycle `done` pulse, and it holds until the next result. A `start` that arrives while a computation is in progress is ignored.

Top module: `cordic_twiddle_gen`

## Requirements
- R1: While reset is asserted (`rst_n` low) and after its release with no start, `done` is 0 and both `cos_out` and `sin_out` are 0.
- R2: `done` is high for exactly one cycle, ITERS (default 9) clock edges after the edge that accepts `start`. In other words, `done` is seen after the (ITERS+1)-th rising edge, counting the accepting edge as the first.
- R3: A `start` that is high from the edge after an accepted `start` up to and including the edge that raises `done` is ignored. The pending result and its timing are unchanged, and no extra `done` follows.
- R4: `angle_in` is unsigned degrees with 8 fractional bits (value = degrees × 256). `cos_out` and `sin_out` are signed two's complement with 14 fractional bits (1.0 = 16384). In the first quadrant (0° ≤ angle < 90°) and outside the snap bands, both outputs are within 0.02 (328 LSB) of the true cosine and sine.
- R5: For 90° ≤ angle < 180°, the working angle is 180° − angle and the cosine is negated. The outputs are within 0.02 of the true values.
- R6: For 180° ≤ angle < 270°, the working angle is angle − 180° and both outputs are negated. The outputs are within 0.02 of the true values.
- R7: For 270° ≤ angle < 360°, the working angle is 360° − angle and the sine is negated. The outputs are within 0.02 of the true values.
- R8: A working angle of 5° or less gives exactly cos = 16384 and sin = 0 before the quadrant signs are applied. For example, 180° gives cos = −16384 and sin = 0.
- R9: A working angle of 85° or more gives exactly cos = 0 and sin = 16384 before the quadrant signs are applied. For example, 270° gives cos = 0 and sin = −16384.
- R10: An angle of 360° or more is not folded and takes no sign flags. Its working angle is therefore at least 85°, and the result is cos = 0 and sin = +16384.
- R11: Between `done` pulses, `cos_out` and `sin_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a computation; accepted only when idle |
| angle_in | input | ANG_W (17) | Unsigned angle, degrees × 2^ANG_FRAC |
| done | output | 1 | One-cycle pulse when a result is presented |
| cos_out | output | DATA_W (16) | Signed cosine, 2^(DATA_W-2) = 1.0 |
| sin_out | output | DATA_W (16) | Signed sine, 2^(DATA_W-2) = 1.0 |

## Verification
A sweep from 0° to 350° in 10° steps lands on every axis and visits each quadrant several times. It therefore separates a wrong reflection or sign flag, which moves the result by far more than the tolerance, from ordinary CORDIC error. Directed angles at 5°, 85°, 95°, 175°, 185°, 265°, 275° and 355° sit exactly on the snap-band edges, where an off-by-one comparison shows up as an inexact axis value. Random angles across the full circle, and above 360°, exercise convergence at arbitrary residuals and the no-fold path. A start pulse inserted mid-computation shows whether a busy request corrupts the result, moves `done`, or creates a second pulse.

// File: rtl/cordic_twiddle_gen.sv
module cordic_twiddle_gen #(
  parameter int ANG_W    = 17,
  parameter int ANG_FRAC = 8,
  parameter int DATA_W   = 16,
  parameter int ITERS    = 9,
  parameter int K_INIT   = 9950
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [ANG_W-1:0]         angle_in,
  output logic                     done,
  output logic signed [DATA_W-1:0] cos_out,
  output logic signed [DATA_W-1:0] sin_out
);
  localparam int ZW = ANG_W + 1;
  localparam int IW = (ITERS > 1) ? $clog2(ITERS) : 1;
  localparam logic [ANG_W-1:0] D90   = ANG_W'(90  << ANG_FRAC);
  localparam logic [ANG_W-1:0] D180  = ANG_W'(180 << ANG_FRAC);
  localparam logic [ANG_W-1:0] D270  = ANG_W'(270 << ANG_FRAC);
  localparam logic [ANG_W-1:0] D360  = ANG_W'(360 << ANG_FRAC);
  localparam logic [ANG_W-1:0] SNAP_LO = ANG_W'(5  << ANG_FRAC);
  localparam logic [ANG_W-1:0] SNAP_HI = ANG_W'(85 << ANG_FRAC);
  localparam logic signed [DATA_W-1:0] ONE  = DATA_W'(1 << (DATA_W-2));
  localparam logic signed [DATA_W-1:0] XSTART = DATA_W'(K_INIT);

  typedef enum logic [1:0] {AX_NONE, AX_ZERO, AX_NINETY} axis_t;

  function automatic logic signed [ZW-1:0] elem_angle(input logic [IW-1:0] i);
    logic [31:0] v;
    case (int'(i))
      0:  v = 32'd2949120;
      1:  v = 32'd1740967;
      2:  v = 32'd919879;
      3:  v = 32'd466945;
      4:  v = 32'd234379;
      5:  v = 32'd117304;
      6:  v = 32'd58666;
      7:  v = 32'd29335;
      8:  v = 32'd14668;
      9:  v = 32'd7334;
      10: v = 32'd3667;
      11: v = 32'd1833;
      12: v = 32'd917;
      13: v = 32'd458;
      14: v = 32'd229;
      15: v = 32'd115;
      default: v = 32'd0;
    endcase
    return ZW'((v + (32'd1 << (15 - ANG_FRAC))) >> (16 - ANG_FRAC));
  endfunction

  logic                     busy;
  logic [IW-1:0]            iter;
  logic signed [DATA_W-1:0] x, y, xn, yn, rc, rs;
  logic signed [ZW-1:0]     z, zn, ea;
  logic                     neg_c, neg_s, f_nc, f_ns;
  axis_t                    axis, f_axis;
  logic [ANG_W-1:0]         w;

  always_comb begin
    f_nc = 1'b0;
    f_ns = 1'b0;
    if (angle_in < D90) begin
      w = angle_in;
    end else if (angle_in < D180) begin
      w = D180 - angle_in;
      f_nc = 1'b1;
    end else if (angle_in < D270) begin
      w = angle_in - D180;
      f_nc = 1'b1;
      f_ns = 1'b1;
    end else if (angle_in < D360) begin
      w = D360 - angle_in;
      f_ns = 1'b1;
    end else begin
      w = angle_in;
    end
    if (w <= SNAP_LO)      f_axis = AX_ZERO;
    else if (w >= SNAP_HI) f_axis = AX_NINETY;
    else                   f_axis = AX_NONE;
  end

  assign ea = elem_angle(iter);

  always_comb begin
    if (!z[ZW-1]) begin
      xn = x - (y >>> iter);
      yn = y + (x >>> iter);
      zn = z - ea;
    end else begin
      xn = x + (y >>> iter);
      yn = y - (x >>> iter);
      zn = z + ea;
    end
    case (axis)
      AX_ZERO:   begin rc = ONE; rs = '0;  end
      AX_NINETY: begin rc = '0;  rs = ONE; end
      default:   begin rc = xn;  rs = yn;  end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      iter    <= '0;
      x       <= '0;
      y       <= '0;
      z       <= '0;
      neg_c   <= 1'b0;
      neg_s   <= 1'b0;
      axis    <= AX_NONE;
      done    <= 1'b0;
      cos_out <= '0;
      sin_out <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          iter  <= '0;
          x     <= XSTART;
          y     <= '0;
          z     <= ZW'(w);
          neg_c <= f_nc;
          neg_s <= f_ns;
          axis  <= f_axis;
        end
      end else begin
        x <= xn;
        y <= yn;
        z <= zn;
        if (iter == IW'(ITERS - 1)) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          cos_out <= neg_c ? -rc : rc;
          sin_out <= neg_s ? -rs : rs;
        end else begin
          iter <= iter + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cordic_twiddle_gen_chk.sv
module cordic_twiddle_gen_chk #(
  parameter int ANG_W    = 17,
  parameter int ANG_FRAC = 8,
  parameter int DATA_W   = 16,
  parameter int ITERS    = 9
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     start,
  input logic [ANG_W-1:0]         angle_in,
  input logic                     done,
  input logic signed [DATA_W-1:0] cos_out,
  input logic signed [DATA_W-1:0] sin_out
);
  localparam int CW = $clog2(ITERS + 2) + 1;
  localparam logic signed [DATA_W-1:0] ONE = DATA_W'(1 << (DATA_W-2));
  localparam logic [ANG_W-1:0] SNAP_LO = ANG_W'(5 << ANG_FRAC);
  localparam logic [ANG_W-1:0] D360    = ANG_W'(360 << ANG_FRAC);

  logic          act;
  logic [CW-1:0] cnt;
  logic [ANG_W-1:0] cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
      cap <= '0;
    end else if (start && (!act || done)) begin
      act <= 1'b1;
      cnt <= '0;
      cap <= angle_in;
    end else if (done) begin
      act <= 1'b0;
    end else if (act) begin
      cnt <= cnt + 1'b1;
    end
  end

  assert_done_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (act && cnt == CW'(ITERS)));
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_out_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cos_out <= ONE && cos_out >= -ONE && sin_out <= ONE && sin_out >= -ONE));
  assert_snap_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap <= SNAP_LO) |-> (cos_out == ONE && sin_out == '0));
  assert_no_fold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap >= D360) |-> (cos_out == '0 && sin_out == ONE));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(cos_out) && $stable(sin_out)));
endmodule

bind cordic_twiddle_gen cordic_twiddle_gen_chk #(
  .ANG_W(ANG_W), .ANG_FRAC(ANG_FRAC), .DATA_W(DATA_W), .ITERS(ITERS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .angle_in(angle_in),
  .done(done), .cos_out(cos_out), .sin_out(sin_out)
);

// File: tb/cordic_twiddle_gen_tb.sv
module cordic_twiddle_gen_tb;
  localparam int ITERS = 9;
  localparam int ONE   = 16384;
  localparam int TOL   = 328;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [16:0] angle_in = '0;
  logic done;
  logic signed [15:0] cos_out, sin_out;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cordic_twiddle_gen u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .angle_in(angle_in),
    .done(done), .cos_out(cos_out), .sin_out(sin_out)
  );

  task automatic check(input string req, input int act, input int exp, input int tol);
    checks++;
    if (act > exp + tol || act < exp - tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (tol %0d)", req, act, exp, tol);
    end
  endtask

  function automatic int rnd(input real v);
    return (v >= 0.0) ? $rtoi(v + 0.5) : $rtoi(v - 0.5);
  endfunction

  function automatic string req_of(input int a);
    int w;
    bit snap;
    if (a >= 92160) return "R10";
    if (a < 23040)      w = a;
    else if (a < 46080) w = 46080 - a;
    else if (a < 69120) w = a - 46080;
    else                w = 92160 - a;
    snap = (w <= 1280) || (w >= 21760);
    if (snap) return (w <= 1280) ? "R8" : "R9";
    if (a < 23040) return "R4";
    if (a < 46080) return "R5";
    if (a < 69120) return "R6";
    return "R7";
  endfunction

  task automatic expected(input int a, output int ec, output int es, output int tol);
    int w;
    bit nc, ns;
    real r;
    nc = 0; ns = 0;
    if (a >= 92160)     begin w = a; end
    else if (a < 23040) begin w = a; end
    else if (a < 46080) begin w = 46080 - a; nc = 1; end
    else if (a < 69120) begin w = a - 46080; nc = 1; ns = 1; end
    else                begin w = 92160 - a; ns = 1; end
    if (w <= 1280) begin
      ec = nc ? -ONE : ONE; es = 0; tol = 0;
    end else if (w >= 21760) begin
      ec = 0; es = ns ? -ONE : ONE; tol = 0;
    end else begin
      r  = (a / 256.0) * 3.14159265358979 / 180.0;
      ec = rnd($cos(r) * ONE);
      es = rnd($sin(r) * ONE);
      tol = TOL;
    end
  endtask

  task automatic run_one(input int a, input int interject, input int b);
    int ec, es, tol, k;
    bit seen;
    string rq;
    @(negedge clk);
    angle_in = 17'(a);
    start = 1'b1;
    seen = 0;
    k = 0;
    for (int n = 1; n <= ITERS + 4; n++) begin
      @(negedge clk);
      if (n == 1) start = 1'b0;
      if (interject > 0 && n == interject) begin
        start = 1'b1;
        angle_in = 17'(b);
      end
      if (interject > 0 && n == interject + 1) start = 1'b0;
      if (done) begin
        seen = 1;
        k = n;
        break;
      end
    end
    check("R2 latency", k, ITERS + 1, 0);
    if (seen) begin
      expected(a, ec, es, tol);
      rq = req_of(a);
      if (interject > 0) rq = {rq, "/R3"};
      check({rq, " cos"}, int'(cos_out), ec, tol);
      check({rq, " sin"}, int'(sin_out), es, tol);
      @(negedge clk);
      check("R2 pulse", int'(done), 0, 0);
      if (interject > 0) begin
        for (int n = 0; n < ITERS + 3; n++) begin
          @(negedge clk);
          if (done) begin
            check("R3 extra done", 1, 0, 0);
            break;
          end
        end
        check("R11 cos hold", int'(cos_out), ec, tol);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int dir [16] = '{1280, 1281, 21759, 21760, 24320, 44800, 47360, 67840,
                     70400, 90880, 92159, 92160, 131071, 46080, 11520, 64000};
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 done", int'(done), 0, 0);
    check("R1 cos", int'(cos_out), 0, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 idle done", int'(done), 0, 0);
    check("R1 idle sin", int'(sin_out), 0, 0);

    for (int d = 0; d < 360; d += 10) run_one(d * 256, 0, 0);
    foreach (dir[i]) run_one(dir[i], 0, 0);

    run_one(40 * 256, 3, 200 * 256);
    run_one(130 * 256, 1, 10 * 256);
    run_one(300 * 256, ITERS, 45 * 256);

    for (int i = 0; i < 60; i++) run_one(int'($urandom % 92160), 0, 0);
    for (int i = 0; i < 6; i++) run_one(92160 + int'($urandom % 38912), 0, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule